// File: doc/BRIEF.md
# Double-Buffered Serial Transmit Path

This block is the transmit side of a synchronous serial port. Software writes a word through a small register port into a holding buffer made of a high half and a low half. Writing the low half commits the word. The committed word then moves into a shift register, either at once or as soon as the word now being sent has put its last bit on the line. A frame sync, sampled on the active edge of an external bit clock, starts the shift-out, most significant bit first.

Word lengths run from 8 to 32 bits. Words longer than 16 bits take their upper bits from the high half. Three 8-bit modes rework the word as it enters the shifter. One reverses its bit order so it leaves least significant bit first. The other two compress a 16-bit linear sample to an 8-bit logarithmic code, using either the mu-law or the A-law curve. The bit clock, the frame sync and any data mover sit outside the block. The system clock samples the bit clock and frame sync, and a polarity input picks which bit-clock edge is active.

Top module: `ser_tx_path`

## Requirements
- R1: After reset `dout_o` is 0, `rdy_o` is 1 and `underflow_o` is 0.
- R2: A write with `wr_sel_i`=1 stores `wr_data_i` as the high half and has no other effect. A write with `wr_sel_i`=0 stores the low half and commits the word, and `rdy_o` is 0 in the cycle after that write.
- R3: When the shifter holds no unsent word, a committed word moves into it on the next clock, and `rdy_o` returns to 1 one cycle after that.
- R4: When the shifter is busy, a committed word waits in the buffer, with `rdy_o` held at 0, until the last bit of the current word has been driven. It then moves in and is the word sent on the next frame.
- R5: No bit leaves until the frame sync is seen high on an active bit-clock edge. That edge drives the first bit, and each later active edge drives the next one. A frame sync that arrives while a word is being sent is ignored.
- R6: With `mode_i`=00 the length code `wlen_i` selects 8, 12, 16, 20, 24 or 32 bits for codes 0 to 5 (6 and 7 also mean 32). The word is the low bits of {high half, low half}, sent MSB first.
- R7: With `mode_i`=01 the word is 8 bits long whatever `wlen_i` says, and low-half bit 0 goes out first, then bit 1, up to bit 7.
- R8: With `mode_i`=10 the low half, read as a 14-bit two's-complement value in bits 15:2, is sent as an 8-bit mu-law code (0x0000 gives 0xFF, 0xFFFC gives 0x7E, 0x7FFC gives 0x80).
- R9: With `mode_i`=11 the low half, read as a 13-bit value in bits 15:3, is sent as an 8-bit A-law code (0x0000 gives 0xD5, 0xFFF8 gives 0x55, 0x7FF8 gives 0xAA).
- R10: `edge_sel_i`=0 makes the rising bit-clock edge active. `edge_sel_i`=1 makes the falling edge active.
- R11: A frame sync that finds the shifter with no unsent word sets `underflow_o` and sends the previous word again. The next low-half write clears `underflow_o`.
- R12: `dout_o` changes only in response to an active bit-clock edge, and it holds the last bit driven between words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 1 selects the high half, 0 the low half (commit) |
| wr_data_i | input | DATA_W | Write data |
| mode_i | input | 2 | 00 MSB first, 01 8-bit LSB first, 10 mu-law, 11 A-law |
| wlen_i | input | 3 | Word length code for mode 00 |
| edge_sel_i | input | 1 | Active bit-clock edge: 0 rising, 1 falling |
| bclk_i | input | 1 | Transmit bit clock |
| fsync_i | input | 1 | Transmit frame sync |
| dout_o | output | 1 | Serial data out |
| rdy_o | output | 1 | Buffer empty, ready for a new word |
| underflow_o | output | 1 | A frame started with no new word |

## Verification
The bench uses the defaults, DATA_W=16 and COMPAND_EN=1. These give the full 32-bit path through both halves and both compression curves. A bit clock of eight system clocks per period leaves time for the input synchronizers. The frame sync is driven as a half-period pulse centred on the active edge, so a design that acts on the wrong edge never starts a frame. Back-to-back commits, a missing word at frame time and a mid-word frame sync all occur in one run with both edge polarities.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  typedef enum logic [1:0] {
    MD_MSB   = 2'b00,
    MD_LSB8  = 2'b01,
    MD_ULAW  = 2'b10,
    MD_ALAW  = 2'b11
  } tx_mode_e;

  // length code to bit count
  function automatic logic [5:0] wlen_bits(input logic [2:0] code);
    case (code)
      3'd0:    return 6'd8;
      3'd1:    return 6'd12;
      3'd2:    return 6'd16;
      3'd3:    return 6'd20;
      3'd4:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/ser_tx_edge.sv
module ser_tx_edge (
  input  logic clk,
  input  logic rst,
  input  logic bclk,
  input  logic fsync,
  input  logic fall_sel,
  output logic act_edge,
  output logic fs_s
);
  logic b0, b1, b2, f0, f1;

  always_ff @(posedge clk) begin
    if (rst) begin
      b0 <= 1'b0; b1 <= 1'b0; b2 <= 1'b0;
      f0 <= 1'b0; f1 <= 1'b0;
    end else begin
      b0 <= bclk;  b1 <= b0;  b2 <= b1;
      f0 <= fsync; f1 <= f0;
    end
  end

  // frame sync stage lines up with the bit clock stage that is compared
  assign act_edge = fall_sel ? (!b1 && b2) : (b1 && !b2);
  assign fs_s     = f1;
endmodule

// File: rtl/ser_tx_compress.sv
module ser_tx_compress #(
  parameter int DATA_W = 16,
  parameter int CODE_W = 8
) (
  input  logic [DATA_W-1:0] din,
  input  logic              alaw,
  output logic [CODE_W-1:0] code
);
  logic signed [13:0] mu_s;
  logic [14:0]        mu_abs, mu_sum;
  logic [12:0]        mu_mag;
  logic [2:0]         mu_seg;
  logic [3:0]         mu_man;
  logic [7:0]         mu_code;

  logic [12:0]        a_s;
  logic               a_pos;
  logic [11:0]        a_mag;
  logic [2:0]         a_seg;
  logic [3:0]         a_man;
  logic [7:0]         a_code;

  logic unused_lsbs;
  assign unused_lsbs = ^din[1:0];

  always_comb begin
    // mu-law: 14-bit sample, bias 33, clip at 8158
    mu_s   = din[15:2];
    mu_abs = mu_s[13] ? (15'd0 - {1'b1, mu_s}) : {1'b0, mu_s};
    mu_sum = mu_abs + 15'd33;
    mu_mag = (mu_abs > 15'd8158) ? 13'd8191 : mu_sum[12:0];
    mu_seg = 3'd0;
    for (int b = 6; b <= 12; b++)
      if (mu_mag[b]) mu_seg = 3'(b - 5);
    mu_man  = 4'(mu_mag >> ({1'b0, mu_seg} + 4'd1));
    mu_code = ~{mu_s[13], mu_seg, mu_man};

    // A-law: 13-bit sample, ones-complement magnitude for negatives
    a_s   = din[15:3];
    a_pos = !a_s[12];
    a_mag = a_pos ? a_s[11:0] : ~a_s[11:0];
    a_seg = 3'd0;
    for (int b = 5; b <= 11; b++)
      if (a_mag[b]) a_seg = 3'(b - 4);
    a_man  = (a_seg == 3'd0) ? a_mag[4:1] : 4'(a_mag >> a_seg);
    a_code = {1'b0, a_seg, a_man} ^ (a_pos ? 8'hD5 : 8'h55);

    code = CODE_W'(alaw ? a_code : mu_code);
  end
endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift #(
  parameter int MAX_W = 32,
  localparam int LEN_W = $clog2(MAX_W + 1),
  localparam int IDX_W = $clog2(MAX_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_edge,
  input  logic             fs,
  input  logic             load,
  input  logic [MAX_W-1:0] load_word,
  input  logic [LEN_W-1:0] load_len,
  output logic             dout,
  output logic             busy,
  output logic             uf_pulse
);
  logic [MAX_W-1:0] word_q, src_word;
  logic [LEN_W-1:0] len_q, src_len;
  logic [IDX_W-1:0] idx_q, first_idx;
  logic             active_q, busy_q, dout_q, start;

  always_comb begin
    start     = act_edge && fs && !active_q;
    src_word  = load ? load_word : word_q;
    src_len   = load ? load_len  : len_q;
    first_idx = IDX_W'(src_len - LEN_W'(1));
    uf_pulse  = start && !busy_q && !load;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q   <= '0;
      len_q    <= LEN_W'(8);
      idx_q    <= '0;
      active_q <= 1'b0;
      busy_q   <= 1'b0;
      dout_q   <= 1'b0;
    end else begin
      if (load) begin
        word_q <= load_word;
        len_q  <= load_len;
        busy_q <= 1'b1;
      end
      if (start) begin
        dout_q   <= src_word[first_idx];
        idx_q    <= first_idx - IDX_W'(1);
        active_q <= 1'b1;
        busy_q   <= 1'b1;
      end else if (active_q && act_edge) begin
        dout_q <= word_q[idx_q];
        if (idx_q == '0) begin
          active_q <= 1'b0;
          busy_q   <= 1'b0;
        end else begin
          idx_q <= idx_q - IDX_W'(1);
        end
      end
    end
  end

  assign dout = dout_q;
  assign busy = busy_q;
endmodule

// File: rtl/ser_tx_path.sv
module ser_tx_path
  import ser_tx_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int CODE_W     = 8,
  parameter bit COMPAND_EN = 1'b1,
  localparam int MAX_W = 2 * DATA_W,
  localparam int LEN_W = $clog2(MAX_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        mode_i,
  input  logic [2:0]        wlen_i,
  input  logic              edge_sel_i,
  input  logic              bclk_i,
  input  logic              fsync_i,
  output logic              dout_o,
  output logic              rdy_o,
  output logic              underflow_o
);
  logic [DATA_W-1:0] hi_q, lo_q;
  logic              buf_full_q, uf_q;
  logic              act_edge, fs_s, sh_busy, uf_pulse, load, wr_lo;
  logic [CODE_W-1:0] cmp_code, rev8;
  logic [MAX_W-1:0]  asm_word;
  logic [LEN_W-1:0]  asm_len;

  ser_tx_edge u_edge (
    .clk(clk), .rst(rst), .bclk(bclk_i), .fsync(fsync_i),
    .fall_sel(edge_sel_i), .act_edge(act_edge), .fs_s(fs_s)
  );

  generate
    if (COMPAND_EN) begin : g_cmp
      ser_tx_compress #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_cmp (
        .din(lo_q), .alaw(mode_i[0]), .code(cmp_code)
      );
    end else begin : g_nocmp
      assign cmp_code = '0;
    end
    for (genvar i = 0; i < CODE_W; i++) begin : g_rev
      assign rev8[i] = lo_q[CODE_W-1-i];
    end
  endgenerate

  // word as it enters the shifter
  always_comb begin
    case (tx_mode_e'(mode_i))
      MD_MSB: begin
        asm_word = {hi_q, lo_q};
        asm_len  = LEN_W'(wlen_bits(wlen_i));
      end
      MD_LSB8: begin
        asm_word = MAX_W'(rev8);
        asm_len  = LEN_W'(CODE_W);
      end
      default: begin
        asm_word = MAX_W'(cmp_code);
        asm_len  = LEN_W'(CODE_W);
      end
    endcase
  end

  assign wr_lo = wr_en_i && !wr_sel_i;
  assign load  = buf_full_q && !sh_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q       <= '0;
      lo_q       <= '0;
      buf_full_q <= 1'b0;
      uf_q       <= 1'b0;
    end else begin
      if (wr_en_i && wr_sel_i) hi_q <= wr_data_i;
      if (wr_lo)               lo_q <= wr_data_i;
      if (wr_lo)               buf_full_q <= 1'b1;
      else if (load)           buf_full_q <= 1'b0;
      if (uf_pulse)            uf_q <= 1'b1;
      else if (wr_lo)          uf_q <= 1'b0;
    end
  end

  ser_tx_shift #(.MAX_W(MAX_W)) u_shift (
    .clk(clk), .rst(rst), .act_edge(act_edge), .fs(fs_s),
    .load(load), .load_word(asm_word), .load_len(asm_len),
    .dout(dout_o), .busy(sh_busy), .uf_pulse(uf_pulse)
  );

  assign rdy_o       = !buf_full_q;
  assign underflow_o = uf_q;
endmodule

// File: rtl/ser_tx_path_chk.sv
module ser_tx_path_chk (
  input logic clk,
  input logic rst,
  input logic wr_en_i,
  input logic wr_sel_i,
  input logic rdy_o,
  input logic dout_o,
  input logic underflow_o,
  input logic act_edge,
  input logic fs_s,
  input logic sh_busy,
  input logic uf_pulse
);
  AST_COMMIT_CLEARS_RDY: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !wr_sel_i) |=> !rdy_o); // R2

  AST_WAIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!rdy_o && sh_busy) |=> !rdy_o); // R4

  AST_DOUT_ON_EDGE_ONLY: assert property (@(posedge clk) disable iff (rst)
    !act_edge |=> $stable(dout_o)); // R12

  AST_UF_NEEDS_FRAME: assert property (@(posedge clk) disable iff (rst)
    $rose(underflow_o) |-> $past(act_edge && fs_s)); // R11

  AST_UF_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !wr_sel_i && !uf_pulse) |=> !underflow_o); // R11
endmodule

bind ser_tx_path ser_tx_path_chk u_chk (
  .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
  .rdy_o(rdy_o), .dout_o(dout_o), .underflow_o(underflow_o),
  .act_edge(act_edge), .fs_s(fs_s), .sh_busy(sh_busy), .uf_pulse(uf_pulse)
);

// File: tb/sim_ser_tx_path.sv
module sim_ser_tx_path;
  logic        clk = 1'b0, rst = 1'b1;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [1:0]  mode = 2'b00;
  logic [2:0]  wlen = 3'd0;
  logic        edge_sel = 1'b0, bclk = 1'b0, fsync = 1'b0;
  logic        dout, rdy, uflow;
  int          nchk = 0, nfail = 0;
  bit          done = 1'b0;

  ser_tx_path u0 (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .mode_i(mode), .wlen_i(wlen),
    .edge_sel_i(edge_sel), .bclk_i(bclk), .fsync_i(fsync),
    .dout_o(dout), .rdy_o(rdy), .underflow_o(uflow)
  );

  always #10 clk = ~clk;                 // 50 MHz
  initial begin #5; forever #80 bclk = ~bclk; end

  // {req, mode, wlen, hi, lo, expected, nbits}
  localparam logic [78:0] VEC [14] = '{
    {4'd6, 2'd0, 3'd0, 16'h0000, 16'h00A5, 32'h000000A5, 6'd8},   // R6
    {4'd6, 2'd0, 3'd1, 16'h0000, 16'h0ABC, 32'h00000ABC, 6'd12},  // R6
    {4'd6, 2'd0, 3'd2, 16'h0000, 16'h8001, 32'h00008001, 6'd16},  // R6
    {4'd6, 2'd0, 3'd3, 16'h000F, 16'h1234, 32'h000F1234, 6'd20},  // R6
    {4'd6, 2'd0, 3'd4, 16'h00C3, 16'h5A5A, 32'h00C35A5A, 6'd24},  // R6
    {4'd6, 2'd0, 3'd5, 16'hDEAD, 16'hBEEF, 32'hDEADBEEF, 6'd32},  // R6
    {4'd7, 2'd1, 3'd5, 16'hFFFF, 16'h0001, 32'h00000080, 6'd8},   // R7
    {4'd7, 2'd1, 3'd0, 16'h0000, 16'h00C5, 32'h000000A3, 6'd8},   // R7
    {4'd8, 2'd2, 3'd0, 16'h0000, 16'h0000, 32'h000000FF, 6'd8},   // R8
    {4'd8, 2'd2, 3'd0, 16'h0000, 16'hFFFC, 32'h0000007E, 6'd8},   // R8
    {4'd8, 2'd2, 3'd0, 16'h0000, 16'h7FFC, 32'h00000080, 6'd8},   // R8
    {4'd9, 2'd3, 3'd0, 16'h0000, 16'h0000, 32'h000000D5, 6'd8},   // R9
    {4'd9, 2'd3, 3'd0, 16'h0000, 16'h7FF8, 32'h000000AA, 6'd8},   // R9
    {4'd9, 2'd3, 3'd0, 16'h0000, 16'hFFF8, 32'h00000055, 6'd8}    // R9
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_act();
    if (edge_sel) @(negedge bclk); else @(posedge bclk);
  endtask
  task automatic wait_inact();
    if (edge_sel) @(posedge bclk); else @(negedge bclk);
  endtask

  // frame sync pulse centred on the active edge; bits sampled at inactive edges
  task automatic frame(input int n, input bit midfs, output logic [31:0] got,
                       output logic mid_rdy);
    got = '0; mid_rdy = 1'b1;
    wait_inact(); #40 fsync = 1'b1;
    wait_act();   #40 fsync = 1'b0;
    wait_inact(); got = {got[30:0], dout};
    for (int i = 1; i < n; i++) begin
      if (midfs && i == 3) begin #40 fsync = 1'b1; end
      wait_act();
      if (midfs && i == 3) begin #40 fsync = 1'b0; end
      wait_inact(); got = {got[30:0], dout};
      if (i == n / 2) mid_rdy = rdy;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    logic        mr;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 dout", 32'(dout), 32'd0);
    chk("R1 rdy", 32'(rdy), 32'd1);
    chk("R1 underflow", 32'(uflow), 32'd0);

    // high-half write alone commits nothing
    wr(1'b1, 16'h1234);
    chk("R2 high write leaves rdy", 32'(rdy), 32'd1);

    for (int i = 0; i < 14; i++) begin
      automatic logic [78:0] v = VEC[i];
      mode = v[74:73]; wlen = v[72:70];
      wr(1'b1, v[69:54]);
      wr(1'b0, v[53:38]);
      chk("R2 rdy after commit", 32'(rdy), 32'd0);
      @(negedge clk);
      chk("R3 rdy after immediate load", 32'(rdy), 32'd1);
      frame(int'(v[5:0]), 1'b0, got, mr);
      chk($sformatf("R%0d vector %0d", v[78:75], i), got, v[37:6]);
    end

    // last bit of 0x55 is 1; line holds it
    repeat (3) wait_act();
    wait_inact();
    chk("R12 hold between words", 32'(dout), 32'd1);

    // new word loaded, no frame sync: line unchanged; mid-word sync ignored
    mode = 2'b00; wlen = 3'd2;
    wr(1'b0, 16'h0F0E);
    repeat (3) wait_act();
    wait_inact();
    chk("R5 no bits before frame sync", 32'(dout), 32'd1);
    frame(16, 1'b1, got, mr);
    chk("R5 mid-word sync ignored", got, 32'h0F0E);

    // back-to-back commits
    wr(1'b0, 16'h1111);
    @(negedge clk);
    wr(1'b0, 16'h2222);
    repeat (3) @(negedge clk);
    chk("R4 rdy low while shifter full", 32'(rdy), 32'd0);
    frame(16, 1'b0, got, mr);
    chk("R4 first word", got, 32'h1111);
    chk("R4 rdy low mid-word", 32'(mr), 32'd0);
    chk("R4 rdy high after last bit", 32'(rdy), 32'd1);
    frame(16, 1'b0, got, mr);
    chk("R4 waiting word sent next", got, 32'h2222);

    // frame with no new word
    frame(16, 1'b0, got, mr);
    chk("R11 previous word resent", got, 32'h2222);
    chk("R11 underflow set", 32'(uflow), 32'd1);
    wr(1'b0, 16'h3333);
    chk("R11 underflow cleared by commit", 32'(uflow), 32'd0);

    // falling edge active
    @(negedge clk); edge_sel = 1'b1;
    frame(16, 1'b0, got, mr);
    chk("R10 falling-edge frame", got, 32'h3333);
    wr(1'b0, 16'hC3A5);
    frame(16, 1'b0, got, mr);
    chk("R10 falling-edge second frame", got, 32'hC3A5);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule